// File: doc/BRIEF.md
# Token Ring Lock Unit

This block sits between one core and a slotted ring and serves as that core's lock manager. Each clock cycle one slot enters the block and one slot leaves it, one register stage later. A slot has a kind, a core number and a data word. While the block has no request in flight it passes slots through unchanged. The one exception is a request from another core for a lock this core holds. The block turns that request into a failure reply, which then travels on to the core that sent it.

To acquire a lock, the CPU pulses an acquire request with a lock number. The block then waits for the circulating token slot. The token's data word counts the request slots already queued behind it. The block forwards the token with that count raised by one. It then lets the counted slots pass and writes its own request into the slot that follows them. If the request comes back around the ring unchanged, the lock is granted. If the request comes back as a failure reply, the lock is refused. In both cases the block consumes the returning slot by emitting a Null slot, and it pulses a done flag together with the outcome. Granted locks are kept in a small table, and a CPU release removes a lock from that table.

Top module: `tr_lock_unit`

## Requirements
- R1: While reset is asserted and after it is released, slot_kind_o is Null (0), slot_id_o and slot_data_o are 0, done_o, granted_o and busy_o are 0, and no lock is held.
- R2: With no request in flight, every input slot appears unchanged on the output one clock later. The exception is the case covered by R7. Slot kinds are encoded Null=0, Token=1, Request=2, Fail=3.
- R3: A block waiting for the token forwards the first Token slot it sees with the data word rewritten from N to N+1 and the core field unchanged.
- R4: After forwarding the token, the block passes the next N slots without inserting anything. It then replaces slot N+1 with a Request slot. That slot has id CORE_ID and data equal to the lock number, zero-extended.
- R5: When a Request slot with id CORE_ID and data equal to the pending lock arrives while awaiting a reply, the block outputs a Null slot with zero id and zero data. It raises done_o with granted_o=1, and the lock becomes held.
- R6: When a Fail slot with id CORE_ID and the pending lock arrives while awaiting a reply, the block outputs a Null slot. It raises done_o with granted_o=0, and the lock does not become held.
- R7: A Request slot from another core whose data equals a held lock number (upper data bits zero) leaves the block as a Fail slot with the same id and data.
- R8: A release pulse with a lock number removes that lock from the held set. Other held locks are unaffected.
- R9: An acquire pulse is ignored while a request is in flight or while all NUM_HELD table entries are occupied.
- R10: busy_o is high from the cycle after an accepted acquire until done_o. done_o is high for exactly one cycle per accepted acquire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_kind_i | input | 2 | Incoming slot kind |
| slot_id_i | input | CORE_W | Incoming slot core number |
| slot_data_i | input | DATA_W | Incoming slot data word |
| slot_kind_o | output | 2 | Outgoing slot kind |
| slot_id_o | output | CORE_W | Outgoing slot core number |
| slot_data_o | output | DATA_W | Outgoing slot data word |
| acq_req_i | input | 1 | Acquire pulse |
| acq_lock_i | input | LOCK_W | Lock number to acquire |
| rel_req_i | input | 1 | Release pulse |
| rel_lock_i | input | LOCK_W | Lock number to release |
| busy_o | output | 1 | Acquire in flight |
| done_o | output | 1 | Acquire resolved this cycle |
| granted_o | output | 1 | Outcome of the resolved acquire |

## Verification
Long runs of random slots with no locks held show that an idle unit is transparent for every kind and id, including its own. Later random runs with a known held set separate the owner's rewrite into a Fail slot from plain forwarding. Directed acquisitions use token counts 0 and 3. These show that the count is incremented and that exactly N slots pass before the request appears. A train that contains another core's request for a held lock shows that owner replies continue during skipping. Separate cases return the request unchanged and return it as a Fail slot, which tells grant apart from refusal. Further cases cover an acquire while busy, an acquire with a full table, a release, and a request whose data lies outside the lock range.

// File: rtl/tr_lock_pkg.sv
package tr_lock_pkg;
  typedef enum logic [1:0] {
    SLOT_NULL  = 2'd0,
    SLOT_TOKEN = 2'd1,
    SLOT_PREQ  = 2'd2,
    SLOT_PFAIL = 2'd3
  } slot_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_TOK, ST_SKIP, ST_APPEND, ST_WAIT_REPLY
  } req_state_e;
endpackage

// File: rtl/tr_lock_table.sv
module tr_lock_table #(
  parameter int NUM_HELD = 4,
  parameter int LOCK_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LOCK_W-1:0] lookup_i,
  output logic              hit_o,
  input  logic              insert_i,
  input  logic [LOCK_W-1:0] insert_lock_i,
  input  logic              release_i,
  input  logic [LOCK_W-1:0] release_lock_i,
  output logic              full_o
);
  localparam int IDX_W = (NUM_HELD > 1) ? $clog2(NUM_HELD) : 1;

  logic [NUM_HELD-1:0]             valid_q;
  logic [NUM_HELD-1:0][LOCK_W-1:0] lock_q;
  logic [NUM_HELD-1:0]             hit_vec, ins_vec, rel_vec;
  logic [IDX_W-1:0]                free_idx;
  logic                            ins_present;

  for (genvar g = 0; g < NUM_HELD; g++) begin : g_match
    assign hit_vec[g] = valid_q[g] && (lock_q[g] == lookup_i);
    assign ins_vec[g] = valid_q[g] && (lock_q[g] == insert_lock_i);
    assign rel_vec[g] = valid_q[g] && (lock_q[g] == release_lock_i);
  end

  assign hit_o       = |hit_vec;
  assign ins_present = |ins_vec;
  assign full_o      = &valid_q;

  always_comb begin
    free_idx = '0;
    for (int i = NUM_HELD - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lock_q  <= '0;
    end else begin
      if (release_i) valid_q <= valid_q & ~rel_vec;
      if (insert_i && !ins_present && !full_o) begin
        valid_q[free_idx] <= 1'b1;
        lock_q[free_idx]  <= insert_lock_i;
      end
    end
  end

  AST_TBL_NO_DUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit_vec) <= 1) else $error("duplicate held lock"); // R5
  AST_TBL_ROOM_ON_INSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_i |-> (!full_o || ins_present)) else $error("insert into full table"); // R9
endmodule

// File: rtl/tr_lock_req_fsm.sv
module tr_lock_req_fsm
  import tr_lock_pkg::*;
#(
  parameter int CORE_W  = 4,
  parameter int DATA_W  = 16,
  parameter int LOCK_W  = 8,
  parameter int CORE_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acq_req_i,
  input  logic [LOCK_W-1:0] acq_lock_i,
  input  logic              full_i,
  input  logic [1:0]        kind_i,
  input  logic [CORE_W-1:0] id_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              tok_take_o,
  output logic              append_o,
  output logic              grant_o,
  output logic              fail_o,
  output logic [LOCK_W-1:0] lock_o
);
  req_state_e        state_q;
  logic [DATA_W-1:0] cnt_q;
  logic [LOCK_W-1:0] lock_q;
  logic              own_slot;

  assign own_slot   = (id_i == CORE_W'(CORE_ID)) && (data_i == DATA_W'(lock_q));
  assign tok_take_o = (state_q == ST_WAIT_TOK) && (kind_i == SLOT_TOKEN);
  assign append_o   = (state_q == ST_APPEND);
  assign grant_o    = (state_q == ST_WAIT_REPLY) && (kind_i == SLOT_PREQ) && own_slot;
  assign fail_o     = (state_q == ST_WAIT_REPLY) && (kind_i == SLOT_PFAIL) && own_slot;
  assign busy_o     = (state_q != ST_IDLE);
  assign lock_o     = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lock_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (acq_req_i && !full_i) begin
          state_q <= ST_WAIT_TOK;
          lock_q  <= acq_lock_i;
        end
        ST_WAIT_TOK: if (tok_take_o) begin
          cnt_q   <= data_i;
          state_q <= (data_i == '0) ? ST_APPEND : ST_SKIP;
        end
        ST_SKIP: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == DATA_W'(1)) state_q <= ST_APPEND;
        end
        ST_APPEND: state_q <= ST_WAIT_REPLY;
        ST_WAIT_REPLY: if (grant_o || fail_o) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SKIP_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> (cnt_q != '0)) else $error("skip with zero count"); // R4
  AST_LOCK_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(lock_q)) else $error("lock changed in flight"); // R9
endmodule

// File: rtl/tr_lock_unit.sv
module tr_lock_unit
  import tr_lock_pkg::*;
#(
  parameter int CORE_W   = 4,
  parameter int DATA_W   = 16,
  parameter int LOCK_W   = 8,
  parameter int NUM_HELD = 4,
  parameter int CORE_ID  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        slot_kind_i,
  input  logic [CORE_W-1:0] slot_id_i,
  input  logic [DATA_W-1:0] slot_data_i,
  output logic [1:0]        slot_kind_o,
  output logic [CORE_W-1:0] slot_id_o,
  output logic [DATA_W-1:0] slot_data_o,
  input  logic              acq_req_i,
  input  logic [LOCK_W-1:0] acq_lock_i,
  input  logic              rel_req_i,
  input  logic [LOCK_W-1:0] rel_lock_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              granted_o
);
  logic              full, held_hit, in_range, foreign_req;
  logic              tok_take, append, grant, fail;
  logic [LOCK_W-1:0] req_lock;
  logic [1:0]        kind_d;
  logic [CORE_W-1:0] id_d;
  logic [DATA_W-1:0] data_d;

  tr_lock_req_fsm #(
    .CORE_W(CORE_W), .DATA_W(DATA_W), .LOCK_W(LOCK_W), .CORE_ID(CORE_ID)
  ) u_req (
    .clk_i, .rst_ni,
    .acq_req_i, .acq_lock_i,
    .full_i    (full),
    .kind_i    (slot_kind_i),
    .id_i      (slot_id_i),
    .data_i    (slot_data_i),
    .busy_o,
    .tok_take_o(tok_take),
    .append_o  (append),
    .grant_o   (grant),
    .fail_o    (fail),
    .lock_o    (req_lock)
  );

  tr_lock_table #(.NUM_HELD(NUM_HELD), .LOCK_W(LOCK_W)) u_tbl (
    .clk_i, .rst_ni,
    .lookup_i      (slot_data_i[LOCK_W-1:0]),
    .hit_o         (held_hit),
    .insert_i      (grant),
    .insert_lock_i (req_lock),
    .release_i     (rel_req_i),
    .release_lock_i(rel_lock_i),
    .full_o        (full)
  );

  assign in_range    = (DATA_W'(slot_data_i[LOCK_W-1:0]) == slot_data_i);
  assign foreign_req = (slot_kind_i == SLOT_PREQ) && (slot_id_i != CORE_W'(CORE_ID));

  always_comb begin
    kind_d = slot_kind_i;
    id_d   = slot_id_i;
    data_d = slot_data_i;
    if (append) begin
      kind_d = SLOT_PREQ;
      id_d   = CORE_W'(CORE_ID);
      data_d = DATA_W'(req_lock);
    end else if (tok_take) begin
      data_d = slot_data_i + 1'b1;
    end else if (grant || fail) begin
      kind_d = SLOT_NULL;
      id_d   = '0;
      data_d = '0;
    end else if (foreign_req && held_hit && in_range) begin
      kind_d = SLOT_PFAIL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_kind_o <= SLOT_NULL;
      slot_id_o   <= '0;
      slot_data_o <= '0;
      done_o      <= 1'b0;
      granted_o   <= 1'b0;
    end else begin
      slot_kind_o <= kind_d;
      slot_id_o   <= id_d;
      slot_data_o <= data_d;
      done_o      <= grant || fail;
      granted_o   <= grant;
    end
  end

  AST_TOKEN_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_take |=> (slot_kind_o == SLOT_TOKEN) && (slot_data_o == $past(slot_data_i) + 1'b1))
    else $error("token count not advanced"); // R3
  AST_PREQ_APPENDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    append |=> (slot_kind_o == SLOT_PREQ) && (slot_id_o == CORE_W'(CORE_ID)))
    else $error("request not appended"); // R4
  AST_REPLY_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (slot_kind_o == SLOT_NULL)) else $error("reply not nulled"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o)) else $error("done without request"); // R10
  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !foreign_req) |=> (slot_kind_o == $past(slot_kind_i)) && (slot_data_o == $past(slot_data_i)))
    else $error("idle slot altered"); // R2
endmodule

// File: tb/tr_lock_unit_tb.sv
module tr_lock_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CORE_W = 4, DATA_W = 16, LOCK_W = 8, NUM_HELD = 4, ME = 3;
  localparam logic [1:0] K_NULL = 2'd0, K_TOK = 2'd1, K_REQ = 2'd2, K_FAIL = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] slot_kind_i = '0, slot_kind_o;
  logic [CORE_W-1:0] slot_id_i = '0, slot_id_o;
  logic [DATA_W-1:0] slot_data_i = '0, slot_data_o;
  logic acq_req_i = 1'b0, rel_req_i = 1'b0;
  logic [LOCK_W-1:0] acq_lock_i = '0, rel_lock_i = '0;
  logic busy_o, done_o, granted_o;

  int checks = 0, fails = 0;
  logic [LOCK_W-1:0] held [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tr_lock_unit #(.CORE_W(CORE_W), .DATA_W(DATA_W), .LOCK_W(LOCK_W),
                 .NUM_HELD(NUM_HELD), .CORE_ID(ME)) dut_i (.*, .clk_i(clk));

  function automatic bit is_held(input logic [DATA_W-1:0] d);
    foreach (held[i]) if (DATA_W'(held[i]) == d) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [1:0] exp_kind(input logic [1:0] k, input logic [CORE_W-1:0] id,
                                          input logic [DATA_W-1:0] d);
    return (k == K_REQ && id != CORE_W'(ME) && is_held(d)) ? K_FAIL : k;
  endfunction

  task automatic step(input logic [1:0] k, input logic [CORE_W-1:0] id, input logic [DATA_W-1:0] d);
    @(negedge clk);
    slot_kind_i = k; slot_id_i = id; slot_data_i = d;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_slot(input string req, input logic [1:0] k, input logic [CORE_W-1:0] id,
                          input logic [DATA_W-1:0] d);
    chk(req, {slot_kind_o, slot_id_o, slot_data_o}, {k, id, d});
  endtask

  task automatic acquire(input logic [LOCK_W-1:0] lk, input int n, input bit win);
    acq_req_i = 1'b1; acq_lock_i = lk;
    step(K_NULL, 0, 0);
    acq_req_i = 1'b0;
    chk("R10 busy after accept", busy_o, 1);
    step(K_TOK, 9, DATA_W'(n));
    chk_slot("R3 token count", K_TOK, 9, DATA_W'(n + 1));
    for (int i = 0; i < n; i++) begin
      step(K_REQ, 4'd1, DATA_W'(8'h60 + i));
      chk_slot("R4 skipped slot", K_REQ, 4'd1, DATA_W'(8'h60 + i));
    end
    step(K_NULL, 0, 0);
    chk_slot("R4 request appended", K_REQ, CORE_W'(ME), DATA_W'(lk));
    step(K_NULL, 0, 0);
    chk("R10 busy while waiting", {busy_o, done_o}, 2'b10);
    step(win ? K_REQ : K_FAIL, CORE_W'(ME), DATA_W'(lk));
    chk_slot(win ? "R5 reply nulled" : "R6 reply nulled", K_NULL, 0, 0);
    chk(win ? "R5 done granted" : "R6 done refused", {done_o, granted_o}, {1'b1, win});
    step(K_NULL, 0, 0);
    chk("R10 done one cycle", {done_o, busy_o}, 2'b00);
    if (win) held.push_back(lk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    chk_slot("R1 reset slot", K_NULL, 0, 0);
    chk("R1 reset flags", {busy_o, done_o, granted_o}, 3'b000);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 after reset", {busy_o, done_o, slot_kind_o}, 4'b0000);

    for (int i = 0; i < 300; i++) begin
      logic [1:0] k = 2'($urandom);
      logic [CORE_W-1:0] id = CORE_W'($urandom);
      logic [DATA_W-1:0] d = DATA_W'($urandom);
      step(k, id, d);
      chk_slot("R2 idle forward", k, id, d);
    end

    acquire(8'h11, 0, 1'b1);

    step(K_REQ, 4'd5, 16'h0011);
    chk_slot("R7 owner rewrites", K_FAIL, 4'd5, 16'h0011);
    step(K_REQ, 4'd5, 16'h0111);
    chk_slot("R7 out of range forwarded", K_REQ, 4'd5, 16'h0111);

    // token count 3, skipped train holds a foreign request for held lock, second acquire ignored
    acq_req_i = 1'b1; acq_lock_i = 8'h22;
    step(K_NULL, 0, 0);
    acq_lock_i = 8'h77;
    step(K_NULL, 0, 0);
    acq_req_i = 1'b0;
    step(K_TOK, 2, 16'd3);
    chk_slot("R3 token count 3", K_TOK, 2, 16'd4);
    step(K_REQ, 4'd6, 16'h0011);
    chk_slot("R7 owner reply while skipping", K_FAIL, 4'd6, 16'h0011);
    step(K_NULL, 0, 0);
    chk_slot("R4 skip second", K_NULL, 0, 0);
    step(K_TOK, 1, 16'h5);
    chk_slot("R4 skip third", K_TOK, 1, 16'h5);
    step(K_NULL, 0, 0);
    chk_slot("R9 busy acquire ignored", K_REQ, CORE_W'(ME), 16'h0022);
    step(K_FAIL, CORE_W'(ME), 16'h0022);
    chk("R6 refused", {done_o, granted_o, slot_kind_o}, {2'b10, K_NULL});
    step(K_REQ, 4'd6, 16'h0022);
    chk_slot("R6 refused lock not held", K_REQ, 4'd6, 16'h0022);

    acquire(8'h30, 3, 1'b1);
    acquire(8'h31, 1, 1'b1);
    acquire(8'h32, 2, 1'b1);
    acq_req_i = 1'b1; acq_lock_i = 8'h50;
    step(K_NULL, 0, 0);
    acq_req_i = 1'b0;
    chk("R9 full table no accept", busy_o, 0);
    step(K_TOK, 2, 16'd7);
    chk_slot("R9 token untouched when full", K_TOK, 2, 16'd7);

    rel_req_i = 1'b1; rel_lock_i = 8'h11;
    step(K_NULL, 0, 0);
    rel_req_i = 1'b0;
    void'(held.pop_front());
    step(K_REQ, 4'd5, 16'h0011);
    chk_slot("R8 released lock forwarded", K_REQ, 4'd5, 16'h0011);
    step(K_REQ, 4'd5, 16'h0030);
    chk_slot("R8 other lock still held", K_FAIL, 4'd5, 16'h0030);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] k = 2'($urandom);
      logic [CORE_W-1:0] id = CORE_W'($urandom_range(0, 2));
      logic [DATA_W-1:0] d = ($urandom % 2) ? DATA_W'(8'h30 + $urandom_range(0, 3)) : DATA_W'($urandom);
      step(k, id, d);
      chk_slot("R7 random owner check", exp_kind(k, id, d), id, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule